// File: doc/BRIEF.md
# Three-Level Crystal Drift Compensator

This block sits between a slow-clock prescaler and the seconds counter of a real-time clock. It runs on the slow clock, divides it down to one-second ticks, and nudges the phase of that division to cancel crystal drift. Adding time makes the prescaler advance by two counts in one cycle, so the next second tick comes one slow-clock cycle early. Subtracting time holds the prescaler for one cycle, so the tick comes one cycle late. Each corrected cycle moves the phase by exactly one slow-clock tick.

There are three correction levels: hourly, daily and monthly. Each level has its own 8-bit setting: a two-digit BCD magnitude in bits 6:0 and a direction flag in bit 7. The calendar logic downstream supplies three position flags: "last minute of the hour", "last hour of the day" and "last day of the month". When the last-minute flag rises, the hourly level is armed. The daily level is also armed if the clock is in the last hour of the day. The monthly level is also armed if, in addition, it is the last day of the month. The armed budgets are then spent one tick per cycle, in the order hour, day, month, for as long as the final minute lasts. Nothing is applied unless the global enable is high.

Top module: `rtc_drift_comp`

## Requirements
- R1: With no correction active, `sec_tick` pulses for one cycle every DIV cycles, and it is low while reset is asserted.
- R2: A setting with bit 7 set adds time. Its magnitude, read as BCD (bits 6:4 tens, bits 3:0 units), is the number of cycles in which the prescaler advances by two, so every later tick arrives that many cycles earlier.
- R3: A setting with bit 7 clear subtracts time. Its BCD magnitude is the number of cycles in which the prescaler holds, so every later tick arrives that many cycles later.
- R4: The exact setting value 0x01 means no correction at that level. A value of 0x81 is a one-tick add.
- R5: While `comp_en` is low, no correction is applied and any budget still pending is discarded.
- R6: A rising edge of `win_last_min` arms the hourly level. The daily level is armed only if `last_hour` is also high, and the monthly level only if `last_hour` and `last_day` are both high. The flags are sampled in the cycle of that edge.
- R7: Armed levels are applied one tick per cycle, never two in the same cycle. All hourly ticks come before daily ticks, and all daily ticks before monthly ticks.
- R8: Corrections are applied only in the cycles after the edge cycle while `win_last_min` stays high. A window that is high for W cycles applies at most W-1 ticks, and any remainder is dropped when the window falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (crystal) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| comp_en | input | 1 | Global correction enable |
| cfg_hour | input | 8 | Hourly setting: bit 7 add/subtract, bits 6:0 BCD magnitude |
| cfg_day | input | 8 | Daily setting, same layout |
| cfg_month | input | 8 | Monthly setting, same layout |
| win_last_min | input | 1 | High during the last minute of each hour |
| last_hour | input | 1 | High during the last hour of a day |
| last_day | input | 1 | High during the last day of a month |
| sec_tick | output | 1 | One-cycle pulse per second to the seconds counter |

## Verification
The assertions take the following for granted about the inputs:
- `win_last_min` is low for at least one cycle between windows.
- The settings hold valid BCD digits.
- DIV is at least 4, so two second ticks can never fall in adjacent cycles even while the prescaler is skipping.

The stimulus meets these by dropping the window for several prescaler periods between scenarios, by building every magnitude through a decimal-to-BCD function, and by using a divider of 64. It measures the phase of `sec_tick` after each window against a count of applied ticks. That count is computed from the settings, the flags, the enable and the window length.

// File: rtl/rtc_comp_pkg.sv
package rtc_comp_pkg;

  localparam int unsigned NUM_LEVELS = 3;
  localparam int unsigned BUDGET_W   = 7;

  // Exact value 8'h01 means "no correction"; otherwise BCD in bits 6:0.
  function automatic logic [BUDGET_W-1:0] setting_to_ticks(input logic [7:0] setting);
    logic [BUDGET_W-1:0] tens;
    logic [BUDGET_W-1:0] units;
    tens  = BUDGET_W'(setting[6:4]);
    units = BUDGET_W'(setting[3:0]);
    if (setting == 8'h01) return '0;
    return tens * BUDGET_W'(10) + units;
  endfunction

endpackage

// File: rtl/rtc_comp_lvl_dec.sv
module rtc_comp_lvl_dec
  import rtc_comp_pkg::*;
(
  input  logic [7:0]          setting,
  output logic [BUDGET_W-1:0] ticks,
  output logic                add_time
);

  always_comb begin
    ticks    = setting_to_ticks(setting);
    add_time = setting[7];
  end

endmodule

// File: rtl/rtc_comp_sched.sv
module rtc_comp_sched
  import rtc_comp_pkg::*;
#(
  parameter int unsigned LEVELS = NUM_LEVELS,
  parameter int unsigned CW     = BUDGET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_en,
  input  logic              win,
  input  logic [LEVELS-1:0] arm,
  input  logic [CW-1:0]     ticks [LEVELS],
  input  logic [LEVELS-1:0] add_time,
  output logic [LEVELS-1:0] lvl_onehot,
  output logic              adj_add
);

  localparam int unsigned SEL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  logic              win_q;
  logic              win_start;
  logic [CW-1:0]     budget [LEVELS];
  logic [LEVELS-1:0] dir_q;
  logic [LEVELS-1:0] pending;
  logic [SEL_W-1:0]  sel;
  logic              any_pending;

  assign win_start = win & ~win_q;

  // Lowest-numbered level with budget left goes first.
  always_comb begin
    sel         = '0;
    any_pending = 1'b0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        sel         = SEL_W'(i);
        any_pending = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_pend
      assign pending[g]    = (budget[g] != '0);
      assign lvl_onehot[g] = any_pending && win && comp_en && (sel == SEL_W'(g));
    end
  endgenerate

  assign adj_add = dir_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      dir_q <= '0;
      for (int i = 0; i < LEVELS; i++) budget[i] <= '0;
    end else begin
      win_q <= win;
      if (!comp_en || !win) begin
        for (int i = 0; i < LEVELS; i++) budget[i] <= '0;
      end else if (win_start) begin
        dir_q <= add_time;
        for (int i = 0; i < LEVELS; i++) budget[i] <= arm[i] ? ticks[i] : '0;
      end else if (any_pending) begin
        budget[sel] <= budget[sel] - CW'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_comp_prescaler.sv
module rtc_comp_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic skip,
  input  logic hold,
  output logic tick
);

  localparam int unsigned CNT_W = $clog2(DIV);
  localparam logic [CNT_W:0] DIV_V = (CNT_W + 1)'(DIV);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       step;
  logic [CNT_W:0]   nxt;

  always_comb begin
    if (hold)      step = 2'd0;
    else if (skip) step = 2'd2;
    else           step = 2'd1;
    nxt = {1'b0, cnt} + (CNT_W + 1)'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (nxt >= DIV_V) begin
      cnt  <= CNT_W'(nxt - DIV_V);
      tick <= 1'b1;
    end else begin
      cnt  <= CNT_W'(nxt);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_drift_comp.sv
module rtc_drift_comp
  import rtc_comp_pkg::*;
#(
  parameter int unsigned DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       comp_en,
  input  logic [7:0] cfg_hour,
  input  logic [7:0] cfg_day,
  input  logic [7:0] cfg_month,
  input  logic       win_last_min,
  input  logic       last_hour,
  input  logic       last_day,
  output logic       sec_tick
);

  logic [7:0]            setting [NUM_LEVELS];
  logic [BUDGET_W-1:0]   ticks   [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] add_time;
  logic [NUM_LEVELS-1:0] arm;
  logic [NUM_LEVELS-2:0] outer_last;
  logic [NUM_LEVELS-1:0] lvl_onehot;
  logic                  adj_add;
  logic                  adj_any;

  assign setting[0]  = cfg_hour;
  assign setting[1]  = cfg_day;
  assign setting[2]  = cfg_month;
  assign outer_last  = {last_day, last_hour};

  genvar g;
  generate
    for (g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      rtc_comp_lvl_dec u_dec (
        .setting  (setting[g]),
        .ticks    (ticks[g]),
        .add_time (add_time[g])
      );
      if (g == 0) begin : g_arm0
        assign arm[g] = 1'b1;
      end else begin : g_armn
        assign arm[g] = arm[g-1] & outer_last[g-1];
      end
    end
  endgenerate

  rtc_comp_sched #(
    .LEVELS (NUM_LEVELS),
    .CW     (BUDGET_W)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .comp_en    (comp_en),
    .win        (win_last_min),
    .arm        (arm),
    .ticks      (ticks),
    .add_time   (add_time),
    .lvl_onehot (lvl_onehot),
    .adj_add    (adj_add)
  );

  assign adj_any = |lvl_onehot;

  rtc_comp_prescaler #(
    .DIV (DIV)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .skip  (adj_any & adj_add),
    .hold  (adj_any & ~adj_add),
    .tick  (sec_tick)
  );

endmodule

// File: rtl/rtc_drift_comp_chk.sv
module rtc_drift_comp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       comp_en,
  input logic       win_last_min,
  input logic [2:0] lvl_onehot,
  input logic       sec_tick
);

  p_single_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_onehot));

  p_day_after_hour_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_onehot[1] |=> !lvl_onehot[0]);

  p_month_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_onehot[2] |=> !(lvl_onehot[0] || lvl_onehot[1]));

  p_inside_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_onehot != 3'b000) |-> $past(win_last_min));

  p_disabled_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_en |=> (lvl_onehot == 3'b000));

  p_tick_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

endmodule

bind rtc_drift_comp rtc_drift_comp_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .comp_en      (comp_en),
  .win_last_min (win_last_min),
  .lvl_onehot   (lvl_onehot),
  .sec_tick     (sec_tick)
);

// File: tb/tb_rtc_drift_comp.sv
`timescale 1ns/1ps
module tb_rtc_drift_comp;

  localparam int DIV = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       comp_en = 1'b0;
  logic [7:0] cfg_hour = 8'h01;
  logic [7:0] cfg_day = 8'h01;
  logic [7:0] cfg_month = 8'h01;
  logic       win_last_min = 1'b0;
  logic       last_hour = 1'b0;
  logic       last_day = 1'b0;
  logic       sec_tick;

  int cyc = 0;
  int n_ticks = 0;
  int first_tick = 0;
  int second_tick = 0;
  int last_tick = 0;
  int checks = 0;
  int errors = 0;
  int exp_phase = 0;
  bit done = 1'b0;

  rtc_drift_comp #(.DIV(DIV)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .comp_en      (comp_en),
    .cfg_hour     (cfg_hour),
    .cfg_day      (cfg_day),
    .cfg_month    (cfg_month),
    .win_last_min (win_last_min),
    .last_hour    (last_hour),
    .last_day     (last_day),
    .sec_tick     (sec_tick)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (rst_n && sec_tick) begin
      n_ticks = n_ticks + 1;
      if (n_ticks == 1) first_tick = cyc;
      else if (n_ticks == 2) second_tick = cyc;
      last_tick = cyc;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int set_ticks(input int s);
    if (s == 1) return 0;
    return ((s >> 4) & 7) * 10 + (s & 15);
  endfunction

  // Signed phase shift a window should produce (positive = time added)
  function automatic int exp_net(input int h, input int d, input int m,
                                 input bit lh, input bit ld, input bit en, input int w);
    int s [3];
    bit a [3];
    int budget;
    int net;
    if (!en) return 0;
    s[0] = h; s[1] = d; s[2] = m;
    a[0] = 1'b1; a[1] = lh; a[2] = lh & ld;
    budget = w - 1;
    net = 0;
    for (int i = 0; i < 3; i++) begin
      int n;
      int take;
      n = a[i] ? set_ticks(s[i]) : 0;
      take = (n < budget) ? n : budget;
      net += ((s[i] & 8'h80) != 0) ? take : -take;
      budget -= take;
    end
    return net;
  endfunction

  task automatic scenario(input string req, input int h, input int d, input int m,
                          input bit lh, input bit ld, input bit en, input int w);
    int net;
    int got;
    @(negedge clk);
    cfg_hour = 8'(h); cfg_day = 8'(d); cfg_month = 8'(m);
    last_hour = lh; last_day = ld; comp_en = en;
    win_last_min = 1'b1;
    repeat (w) @(negedge clk);
    win_last_min = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    net = exp_net(h, d, m, lh, ld, en, w);
    exp_phase = (((exp_phase - net) % DIV) + DIV) % DIV;
    got = (((last_tick - first_tick) % DIV) + DIV) % DIV;
    check(req, got, exp_phase);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset tick low", int'(sec_tick), 0);
    rst_n = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    check("R1 period", second_tick - first_tick, DIV);

    scenario("R2 hourly add 7", 8'h87, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 40);
    scenario("R3 hourly sub 12", 8'h12, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 40);
    scenario("R4 value 0x01 no-op", 8'h01, 8'h01, 8'h01, 1'b1, 1'b1, 1'b1, 40);
    scenario("R4 value 0x81 one add", 8'h81, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 40);
    scenario("R5 disabled", 8'h85, 8'h85, 8'h85, 1'b1, 1'b1, 1'b0, 40);
    scenario("R6 day not armed", 8'h83, 8'h89, 8'h89, 1'b0, 1'b1, 1'b1, 40);
    scenario("R6 day armed month not", 8'h83, 8'h09, 8'h89, 1'b1, 1'b0, 1'b1, 40);
    scenario("R7 all three levels", 8'h84, 8'h06, 8'h88, 1'b1, 1'b1, 1'b1, 40);
    scenario("R8 truncated window", 8'h20, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 5);
    scenario("R8 truncation in day level", 8'h83, 8'h15, 8'h87, 1'b1, 1'b1, 1'b1, 8);
    scenario("R7 R8 month cut off", 8'h02, 8'h82, 8'h09, 1'b1, 1'b1, 1'b1, 6);

    for (int k = 0; k < 10; k++) begin
      int h, d, m;
      h = to_bcd(int'($urandom % 16)) | (int'($urandom % 2) << 7);
      d = to_bcd(int'($urandom % 16)) | (int'($urandom % 2) << 7);
      m = to_bcd(int'($urandom % 16)) | (int'($urandom % 2) << 7);
      scenario("R2 R3 R6 R7 R8 random", h, d, m, 1'($urandom % 2), 1'($urandom % 2),
               1'(($urandom % 4) != 0), 2 + int'($urandom % 40));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule